// File: doc/BRIEF.md
# Indirect Page-Entry List Loader

This block runs one indirect table-update command. The command names a starting IO address, the base of a list of 64-bit entries in memory, and how many entries to take from that list. The command also carries a flag that says whether a translation table answers to the requested identifier. If the command passes its validity checks, the loader fetches the entries one at a time over a simple memory read request/response port. It hands each entry to the translation table's put port, and the entries land on consecutive table pages starting at the page that holds the IO address.

Each command ends with a one-cycle done pulse, a status code and an entry index. The status is success, a parameter error, or the first failing code that the table returned. The index is that of the last entry written successfully. It is zero when nothing was written or when the very first put failed. The memory and the table are outside the block. Only one request, either a read or a put, is in flight at any time.

Top module: `indirect_list_loader`

## Requirements
- R1: A command accepted with `tableMatch` low issues no read or put. `doneValid` is high in the cycle after the accepting edge, with `status` = 8'hF4 (parameter error) and `lastIndex` = 0.
- R2: A page count above 512 is rejected the same way as in R1. A count of exactly 512 is accepted and runs all 512 entries.
- R3: A list base with any of its low 12 address bits set is rejected the same way as in R1.
- R4: A page count of zero issues no read and no put, and ends with `status` = 8'hF4 and `lastIndex` = 0.
- R5: Entry i is read at (list base with bits 1:0 cleared) + 8·i. Each `rdReq` lasts one cycle, and no new read or put starts until the previous one has been answered.
- R6: Entry i is put at (IO address with its low 12 bits cleared) + 4096·i. `putEntry` equals the data returned for that read, and `putReq` rises in the cycle after `rdValid`.
- R7: When every put returns 8'h00, the command ends with `status` = 8'h00 and `lastIndex` = count − 1.
- R8: The first put that returns a non-zero code ends the command. No further reads or puts follow. `status` equals that code, and `lastIndex` is the failing index minus one, or 0 if the failing index is 0.
- R9: `cmdStart` is ignored while `busy` is high.
- R10: After reset, `busy`, `doneValid`, `rdReq` and `putReq` are low, with `status` = 8'h00 and `lastIndex` = 0. `doneValid` is a one-cycle pulse. `status` and `lastIndex` hold their values until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start a command (sampled while idle) |
| tableMatch | input | 1 | A table exists for the requested identifier |
| ioAddr | input | ADDR_W | Starting IO address |
| listBase | input | ADDR_W | Memory address of the entry list |
| pageCount | input | CNT_W | Number of entries to load |
| busy | output | 1 | Command in progress |
| doneValid | output | 1 | One-cycle pulse at command end |
| status | output | 8 | Final status code |
| lastIndex | output | IDX_W | Last successful entry index, or 0 |
| rdReq | output | 1 | Memory read request pulse |
| rdAddr | output | ADDR_W | Memory read address |
| rdValid | input | 1 | Read data valid |
| rdData | input | ENTRY_W | Read data |
| putReq | output | 1 | Table put request pulse |
| putAddr | output | ADDR_W | Page-aligned IO address for the put |
| putEntry | output | ENTRY_W | Entry to write |
| putDone | input | 1 | Put completed |
| putStatus | input | 8 | Put result code (8'h00 = success) |

## Verification
A wrong entry pointer or page counter shows up on the very next `rdReq` or `putReq` as an address off its 8-byte or 4096-byte stride, so every address in a run is compared against the computed sequence. A corrupted sequencer state shows within a handshake: an overlapping request, a put that does not follow read data, or a lost done pulse. A wrong index or a misrouted failure code appears only at the end of a command, on `status` and `lastIndex`. Those outputs are checked at the done pulse and again one cycle later.

// File: rtl/loader_pkg.sv
package loader_pkg;

  localparam int STATUS_W = 8;
  localparam logic [STATUS_W-1:0] STATUS_OK    = 8'h00;
  localparam logic [STATUS_W-1:0] STATUS_PARAM = 8'hF4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT_RD,
    ST_PUT,
    ST_WAIT_PUT,
    ST_DONE
  } loadState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;        // capture command, preset result to parameter error
    logic grabEntry;   // latch returned read data
    logic step;        // advance to next entry / page
    logic finishOk;    // all entries written
    logic finishFail;  // put returned an error
  } loadStrobe_t;

endpackage

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import loader_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic        cmdBad,
  input  logic        lastEntry,
  input  logic        putFail,
  input  logic        rdValid,
  input  logic        putDone,
  output loadStrobe_t strobe,
  output logic        rdReq,
  output logic        putReq,
  output logic        busy,
  output logic        doneValid
);

  loadState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          strobe.load = 1'b1;
          stateNext   = cmdBad ? ST_DONE : ST_FETCH;
        end
      end
      ST_FETCH:   stateNext = ST_WAIT_RD;
      ST_WAIT_RD: begin
        if (rdValid) begin
          strobe.grabEntry = 1'b1;
          stateNext        = ST_PUT;
        end
      end
      ST_PUT:     stateNext = ST_WAIT_PUT;
      ST_WAIT_PUT: begin
        if (putDone) begin
          if (putFail) begin
            strobe.finishFail = 1'b1;
            stateNext         = ST_DONE;
          end else if (lastEntry) begin
            strobe.finishOk = 1'b1;
            stateNext       = ST_DONE;
          end else begin
            strobe.step = 1'b1;
            stateNext   = ST_FETCH;
          end
        end
      end
      ST_DONE:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  assign rdReq     = (state == ST_FETCH);
  assign putReq    = (state == ST_PUT);
  assign doneValid = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/loader_dp.sv
module loader_dp
  import loader_pkg::*;
#(
  parameter int ADDR_W          = 48,
  parameter int ENTRY_W         = 64,
  parameter int CNT_W           = 16,
  parameter int MAX_PAGES       = 512,
  parameter int PAGE_SHIFT      = 12,
  parameter int LIST_ALIGN_BITS = 12,
  parameter int IDX_W           = $clog2(MAX_PAGES)
)(
  input  logic                clk,
  input  logic                rstN,
  input  loadStrobe_t         strobe,
  input  logic                tableMatch,
  input  logic [ADDR_W-1:0]   ioAddr,
  input  logic [ADDR_W-1:0]   listBase,
  input  logic [CNT_W-1:0]    pageCount,
  input  logic [ENTRY_W-1:0]  rdData,
  input  logic [STATUS_W-1:0] putStatus,
  output logic                cmdBad,
  output logic                lastEntry,
  output logic                putFail,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic [ADDR_W-1:0]   putAddr,
  output logic [ENTRY_W-1:0]  putEntry,
  output logic [STATUS_W-1:0] status,
  output logic [IDX_W-1:0]    lastIndex
);

  localparam int CNTR_W = $clog2(MAX_PAGES + 1);
  localparam logic [ADDR_W-1:0] PAGE_STEP  = ADDR_W'(1) << PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] PAGE_MASK  = ~(PAGE_STEP - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] ENTRY_STEP = ADDR_W'(ENTRY_W / 8);
  localparam logic [ADDR_W-1:0] PERM_CLR   = ~ADDR_W'(3);

  logic [ADDR_W-1:0]  ioCur, listPtr;
  logic [ENTRY_W-1:0] entryReg;
  logic [IDX_W-1:0]   idx;
  logic [CNTR_W-1:0]  cntReg;

  // Up-front validation from raw command inputs
  always_comb begin
    cmdBad = !tableMatch
           || (pageCount > CNT_W'(MAX_PAGES))
           || (pageCount == '0)
           || (|listBase[LIST_ALIGN_BITS-1:0]);
  end

  assign lastEntry = (CNTR_W'(idx) + CNTR_W'(1)) == cntReg;
  assign putFail   = (putStatus != STATUS_OK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioCur     <= '0;
      listPtr   <= '0;
      entryReg  <= '0;
      idx       <= '0;
      cntReg    <= '0;
      status    <= STATUS_OK;
      lastIndex <= '0;
    end else begin
      if (strobe.load) begin
        ioCur     <= ioAddr & PAGE_MASK;
        listPtr   <= listBase & PERM_CLR;
        idx       <= '0;
        cntReg    <= pageCount[CNTR_W-1:0];
        status    <= STATUS_PARAM;
        lastIndex <= '0;
      end
      if (strobe.grabEntry) entryReg <= rdData;
      if (strobe.step) begin
        idx     <= idx + IDX_W'(1);
        ioCur   <= ioCur + PAGE_STEP;
        listPtr <= listPtr + ENTRY_STEP;
      end
      if (strobe.finishOk) begin
        status    <= STATUS_OK;
        lastIndex <= idx;
      end
      if (strobe.finishFail) begin
        status    <= putStatus;
        lastIndex <= (idx == '0) ? '0 : idx - IDX_W'(1);
      end
    end
  end

  assign rdAddr   = listPtr;
  assign putAddr  = ioCur;
  assign putEntry = entryReg;

endmodule

// File: rtl/indirect_list_loader.sv
module indirect_list_loader
  import loader_pkg::*;
#(
  parameter int ADDR_W          = 48,
  parameter int ENTRY_W         = 64,
  parameter int CNT_W           = 16,
  parameter int MAX_PAGES       = 512,
  parameter int PAGE_SHIFT      = 12,
  parameter int LIST_ALIGN_BITS = 12,
  localparam int IDX_W          = $clog2(MAX_PAGES)
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdStart,
  input  logic                tableMatch,
  input  logic [ADDR_W-1:0]   ioAddr,
  input  logic [ADDR_W-1:0]   listBase,
  input  logic [CNT_W-1:0]    pageCount,
  output logic                busy,
  output logic                doneValid,
  output logic [STATUS_W-1:0] status,
  output logic [IDX_W-1:0]    lastIndex,
  output logic                rdReq,
  output logic [ADDR_W-1:0]   rdAddr,
  input  logic                rdValid,
  input  logic [ENTRY_W-1:0]  rdData,
  output logic                putReq,
  output logic [ADDR_W-1:0]   putAddr,
  output logic [ENTRY_W-1:0]  putEntry,
  input  logic                putDone,
  input  logic [STATUS_W-1:0] putStatus
);

  loadStrobe_t strobe;
  logic cmdBad, lastEntry, putFail;

  loader_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdStart  (cmdStart),
    .cmdBad    (cmdBad),
    .lastEntry (lastEntry),
    .putFail   (putFail),
    .rdValid   (rdValid),
    .putDone   (putDone),
    .strobe    (strobe),
    .rdReq     (rdReq),
    .putReq    (putReq),
    .busy      (busy),
    .doneValid (doneValid)
  );

  loader_dp #(
    .ADDR_W          (ADDR_W),
    .ENTRY_W         (ENTRY_W),
    .CNT_W           (CNT_W),
    .MAX_PAGES       (MAX_PAGES),
    .PAGE_SHIFT      (PAGE_SHIFT),
    .LIST_ALIGN_BITS (LIST_ALIGN_BITS),
    .IDX_W           (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .tableMatch (tableMatch),
    .ioAddr     (ioAddr),
    .listBase   (listBase),
    .pageCount  (pageCount),
    .rdData     (rdData),
    .putStatus  (putStatus),
    .cmdBad     (cmdBad),
    .lastEntry  (lastEntry),
    .putFail    (putFail),
    .rdAddr     (rdAddr),
    .putAddr    (putAddr),
    .putEntry   (putEntry),
    .status     (status),
    .lastIndex  (lastIndex)
  );

endmodule

// File: rtl/loader_checker.sv
module loader_checker
  import loader_pkg::*;
#(
  parameter int ADDR_W          = 48,
  parameter int CNT_W           = 16,
  parameter int MAX_PAGES       = 512,
  parameter int PAGE_SHIFT      = 12,
  parameter int LIST_ALIGN_BITS = 12,
  parameter int IDX_W           = 9
)(
  input logic                clk,
  input logic                rstN,
  input logic                cmdStart,
  input logic                tableMatch,
  input logic [ADDR_W-1:0]   listBase,
  input logic [CNT_W-1:0]    pageCount,
  input logic                busy,
  input logic                doneValid,
  input logic [STATUS_W-1:0] status,
  input logic [IDX_W-1:0]    lastIndex,
  input logic                rdReq,
  input logic [ADDR_W-1:0]   rdAddr,
  input logic                rdValid,
  input logic                putReq,
  input logic [ADDR_W-1:0]   putAddr
);

  logic accept;
  logic [31:0] readsSinceCmd;
  assign accept = cmdStart && !busy;

  always_ff @(posedge clk) begin
    if (!rstN)       readsSinceCmd <= '0;
    else if (accept) readsSinceCmd <= '0;
    else if (rdReq)  readsSinceCmd <= readsSinceCmd + 32'd1;
  end

  p_reject_nomatch_r1: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !tableMatch) |=> (doneValid && status == STATUS_PARAM && lastIndex == '0));

  p_reject_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && pageCount > CNT_W'(MAX_PAGES)) |=> (doneValid && status == STATUS_PARAM));

  p_read_budget_r2: assert property (@(posedge clk) disable iff (!rstN)
    readsSinceCmd <= 32'(MAX_PAGES));

  p_reject_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (|listBase[LIST_ALIGN_BITS-1:0])) |=> (doneValid && status == STATUS_PARAM));

  p_zero_noread_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && pageCount == '0) |=> (doneValid && !rdReq));

  p_read_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  p_read_stride_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdAddr[2:0] == 3'b000));

  p_put_after_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    putReq |-> $past(rdValid));

  p_put_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    putReq |-> (putAddr[PAGE_SHIFT-1:0] == '0));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && !$past(cmdStart)) |-> ($stable(status) && $stable(lastIndex)));

endmodule

bind indirect_list_loader loader_checker #(
  .ADDR_W          (ADDR_W),
  .CNT_W           (CNT_W),
  .MAX_PAGES       (MAX_PAGES),
  .PAGE_SHIFT      (PAGE_SHIFT),
  .LIST_ALIGN_BITS (LIST_ALIGN_BITS),
  .IDX_W           (IDX_W)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .cmdStart   (cmdStart),
  .tableMatch (tableMatch),
  .listBase   (listBase),
  .pageCount  (pageCount),
  .busy       (busy),
  .doneValid  (doneValid),
  .status     (status),
  .lastIndex  (lastIndex),
  .rdReq      (rdReq),
  .rdAddr     (rdAddr),
  .rdValid    (rdValid),
  .putReq     (putReq),
  .putAddr    (putAddr)
);

// File: tb/indirect_list_loader_test.sv
`timescale 1ns/1ps
module indirect_list_loader_test;

  localparam int ADDR_W = 48;
  localparam int ENTRY_W = 64;
  localparam int CNT_W = 16;
  localparam int IDX_W = 9;
  localparam int LOG_N = 2048;
  localparam logic [7:0] ST_OK = 8'h00;
  localparam logic [7:0] ST_PARAM = 8'hF4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0;
  logic tableMatch = 1'b0;
  logic [ADDR_W-1:0] ioAddr = '0;
  logic [ADDR_W-1:0] listBase = '0;
  logic [CNT_W-1:0] pageCount = '0;
  logic busy, doneValid, rdReq, putReq;
  logic [7:0] status;
  logic [IDX_W-1:0] lastIndex;
  logic [ADDR_W-1:0] rdAddr, putAddr;
  logic [ENTRY_W-1:0] putEntry;
  logic rdValid = 1'b0;
  logic [ENTRY_W-1:0] rdData = '0;
  logic putDone = 1'b0;
  logic [7:0] putStatus = '0;

  int checks = 0;
  int errors = 0;
  int failAt = -1;
  logic [7:0] failCode = 8'h00;

  always #10 clk = ~clk;

  indirect_list_loader uut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .tableMatch(tableMatch),
    .ioAddr(ioAddr), .listBase(listBase), .pageCount(pageCount),
    .busy(busy), .doneValid(doneValid), .status(status), .lastIndex(lastIndex),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .putReq(putReq), .putAddr(putAddr), .putEntry(putEntry),
    .putDone(putDone), .putStatus(putStatus)
  );

  function automatic logic [ENTRY_W-1:0] entryOf(input logic [ADDR_W-1:0] a);
    return {8'hE0, a + 48'h0000_1234_5671, 8'h03};
  endfunction

  // Memory and table models with logs
  logic [ADDR_W-1:0] rdLog [LOG_N];
  logic [ADDR_W-1:0] putALog [LOG_N];
  logic [ENTRY_W-1:0] putELog [LOG_N];
  int nRd = 0, nPut = 0, overlap = 0;
  logic rdBusy = 1'b0, putBusy = 1'b0;
  int rdWait = 0, putWait = 0, putIdx = 0, cmdBaseSeen = 0;
  logic [ADDR_W-1:0] rdAddrQ = '0;

  always @(posedge clk) begin
    if (rdValid) rdValid <= 1'b0;
    if (putDone) putDone <= 1'b0;
    if (rdReq) begin
      if (rdBusy || putBusy) overlap <= overlap + 1;
      if (nRd < LOG_N) rdLog[nRd] <= rdAddr;
      nRd <= nRd + 1;
      rdBusy <= 1'b1;
      rdWait <= rdAddr[3] ? 3 : 1;
      rdAddrQ <= rdAddr;
    end else if (rdBusy) begin
      if (rdWait == 1) begin
        rdValid <= 1'b1;
        rdData <= entryOf(rdAddrQ);
        rdBusy <= 1'b0;
      end else rdWait <= rdWait - 1;
    end
    if (putReq) begin
      if (rdBusy || putBusy) overlap <= overlap + 1;
      if (nPut < LOG_N) begin
        putALog[nPut] <= putAddr;
        putELog[nPut] <= putEntry;
      end
      putIdx <= nPut - cmdBaseSeen;
      nPut <= nPut + 1;
      putBusy <= 1'b1;
      putWait <= 2;
    end else if (putBusy) begin
      if (putWait == 1) begin
        putDone <= 1'b1;
        putStatus <= (putIdx == failAt) ? failCode : ST_OK;
        putBusy <= 1'b0;
      end else putWait <= putWait - 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Issue one command and check every observable result.
  task automatic runCmd(input string req, input logic match, input logic [ADDR_W-1:0] io,
                        input logic [ADDR_W-1:0] base, input int cnt, input int fAt,
                        input logic [7:0] fCode, input logic probeBusy);
    int rb, pb, expN, waited, badRd, badPA, badPE;
    logic reject;
    logic [7:0] expSt;
    logic [IDX_W-1:0] expIdx;
    logic [7:0] heldSt;
    logic [IDX_W-1:0] heldIdx;
    rb = nRd; pb = nPut;
    failAt = fAt; failCode = fCode;
    reject = !match || cnt > 512 || cnt == 0 || (base[11:0] != 12'h0);
    @(negedge clk);
    cmdBaseSeen = nPut;
    tableMatch = match; ioAddr = io; listBase = base; pageCount = CNT_W'(cnt);
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    if (reject) chk({req, " done one cycle after reject"}, 64'(doneValid), 64'd1);
    if (probeBusy) begin
      repeat (7) @(negedge clk);
      chk("R9 busy while running", 64'(busy), 64'd1);
      tableMatch = 1'b0; pageCount = 16'd0; cmdStart = 1'b1;   // must be ignored
      @(negedge clk);
      cmdStart = 1'b0;
    end
    waited = 0;
    while (!doneValid && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk({req, " done seen"}, 64'(doneValid), 64'd1);
    if (reject) begin
      expN = 0; expSt = ST_PARAM; expIdx = '0;
    end else if (fAt >= 0 && fAt < cnt) begin
      expN = fAt + 1; expSt = fCode; expIdx = (fAt == 0) ? '0 : IDX_W'(fAt - 1);
    end else begin
      expN = cnt; expSt = ST_OK; expIdx = IDX_W'(cnt - 1);
    end
    chk({req, " status"}, 64'(status), 64'(expSt));
    chk({req, " lastIndex"}, 64'(lastIndex), 64'(expIdx));
    chk({req, " R5 read count"}, 64'(nRd - rb), 64'(expN));
    chk({req, " R6 put count"}, 64'(nPut - pb), 64'(expN));
    badRd = 0; badPA = 0; badPE = 0;
    for (int i = 0; i < expN && (rb + i) < LOG_N; i++) begin
      logic [ADDR_W-1:0] ea, pa;
      ea = (base & ~48'h3) + 48'(8 * i);
      pa = (io & ~48'hFFF) + 48'(4096 * i);
      if (rdLog[rb + i] !== ea) badRd++;
      if (putALog[pb + i] !== pa) badPA++;
      if (putELog[pb + i] !== entryOf(ea)) badPE++;
    end
    chk({req, " R5 read addresses"}, 64'(badRd), 64'd0);
    chk({req, " R6 put addresses"}, 64'(badPA), 64'd0);
    chk({req, " R6 put entries"}, 64'(badPE), 64'd0);
    chk({req, " R5 no overlap"}, 64'(overlap), 64'd0);
    heldSt = status; heldIdx = lastIndex;
    @(negedge clk);
    chk("R10 done is one pulse", 64'(doneValid), 64'd0);
    repeat (3) @(negedge clk);
    chk("R10 status held", 64'(status), 64'(heldSt));
    chk("R10 lastIndex held", 64'(lastIndex), 64'(heldIdx));
    chk("R10 idle after done", 64'(busy), 64'd0);
  endtask

  task automatic testReset();
    chk("R10 reset busy", 64'(busy), 64'd0);
    chk("R10 reset done", 64'(doneValid), 64'd0);
    chk("R10 reset rdReq", 64'(rdReq), 64'd0);
    chk("R10 reset putReq", 64'(putReq), 64'd0);
    chk("R10 reset status", 64'(status), 64'(ST_OK));
    chk("R10 reset lastIndex", 64'(lastIndex), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runCmd("R1 no table", 1'b0, 48'h1_0000, 48'h20_0000, 4, -1, 8'h00, 1'b0);
    runCmd("R2 count 513", 1'b1, 48'h1_0000, 48'h20_0000, 513, -1, 8'h00, 1'b0);
    runCmd("R3 base bit 11", 1'b1, 48'h1_0000, 48'h20_0800, 4, -1, 8'h00, 1'b0);
    runCmd("R3 base bit 0", 1'b1, 48'h1_0000, 48'h20_0001, 4, -1, 8'h00, 1'b0);
    runCmd("R4 zero count", 1'b1, 48'h1_0000, 48'h20_0000, 0, -1, 8'h00, 1'b0);
    runCmd("R7 five entries", 1'b1, 48'h12_3456, 48'h30_1000, 5, -1, 8'h00, 1'b0);
    runCmd("R7 one entry", 1'b1, 48'hABC_DFFF, 48'h40_0000, 1, -1, 8'h00, 1'b0);
    runCmd("R8 fail at 2", 1'b1, 48'h5_0000, 48'h50_0000, 6, 2, 8'h21, 1'b0);
    runCmd("R8 fail at 0", 1'b1, 48'h5_0000, 48'h50_0000, 6, 0, 8'h07, 1'b0);
    runCmd("R8 fail at last", 1'b1, 48'h7_0000, 48'h51_0000, 3, 2, 8'h33, 1'b0);
    runCmd("R9 start while busy", 1'b1, 48'h9_0000, 48'h60_0000, 8, -1, 8'h00, 1'b1);
    runCmd("R2 count 512", 1'b1, 48'h100_0000, 48'h70_0000, 512, -1, 8'h00, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule